// File: doc/BRIEF.md
# Power Factor Stage Mode and Protection Sequencer

This block supervises a boost power factor stage. It picks the operating mode of the stage from the sensed output voltage and the estimated load. Start-up mode runs until the output voltage has charged to its nominal level. Normal mode is used after that. Burst mode is used when the load is light. The block also keeps the switching enable low while a protection condition is present: standby, over-temperature, output overvoltage, or the hiccup shutdown that follows a lasting overpower condition.

Every input is a plain control or status pin that is sampled on each clock. No data streams through the block, so it has no valid/ready handshake and no back-pressure. The feedback and power codes are unsigned percentages. A millisecond tick pulse times every interval. All state is registered. An input sampled at a clock edge is visible on the outputs just after that edge.

Top module: `pfc_mode_seq`

## Requirements
- R1: In start-up mode (mode code 2'b00) the block stays in start-up while the feedback code is below 99. It moves to normal mode (2'b01) at the edge that samples a feedback code of 99 or more.
- R2: From normal or burst mode, the block returns to start-up at the edge that samples a feedback code below 90. Codes from 90 to 98 do not move it in either direction.
- R3: In normal mode, a power code below 5 puts the block into burst mode (2'b10). In burst mode, a power code of 5 or more returns it to normal. A feedback code below 90 takes precedence and leads to start-up.
- R4: On entry to burst mode, the skip output goes high for BURST_MS ticks. It is then low for BURST_MS ticks, and this alternation continues. Gate enable is low while skip is high. Skip is low outside burst mode.
- R5: A feedback code above 108 clears gate enable at the next edge. Gate enable stays low until the feedback code is 101 or less.
- R6: The overpower condition is set by a power code of 125 or more. It is cleared only by a code below 120. The persistence timer returns to zero whenever the condition is clear.
- R7: After OPW_MS ticks (112 by default) of continuous overpower, gate enable is held low for HICCUP_MS ticks (3000 by default). The sequence then restarts from a zero persistence count, so it repeats while the overpower remains.
- R8: A low standby input clears gate enable at the next edge, in any mode. It does not change the mode code.
- R9: A high thermal flag clears gate enable at the next edge. Gate enable returns only after TEMP_CLR_MS consecutive ticks (16 by default) with the flag low. A high flag during the countdown restarts it.
- R10: During and just after reset, the mode is start-up, the gate enable is low and the skip output is low. The standby input is treated as active until it is first sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| fb_i | input | FB_W | Output-voltage feedback, percent of reference |
| pwr_i | input | FB_W | Estimated output power, percent of rated |
| ot_i | input | 1 | Over-temperature flag, active high |
| stby_n_i | input | 1 | Standby request, active low |
| mode_o | output | 2 | 00 start-up, 01 normal, 10 burst |
| gate_en_o | output | 1 | Switching enable for the pulse generator |
| burst_skip_o | output | 1 | High while a burst period is being skipped |

## Verification
The assertions assume that the tick is a single-cycle pulse and that the codes hold steady between the edges that sample them. They also assume that the standby and thermal inputs are already synchronous to the clock. The stimulus changes every input one time unit after a rising edge and raises the tick for exactly one cycle at a time, so the inputs stay within these assumptions. The threshold codes are driven at their exact limits and one step past them. This places every hysteresis boundary on the edge where it must switch.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_STARTUP = 2'b00,
    MODE_NORMAL  = 2'b01,
    MODE_BURST   = 2'b10
  } pfc_mode_e;
endpackage

// File: rtl/pfc_mode_fsm.sv
module pfc_mode_fsm
  import pfc_seq_pkg::*;
#(
  parameter int unsigned FB_W     = 8,
  parameter int unsigned NORM_PCT = 99,
  parameter int unsigned UV_PCT   = 90,
  parameter int unsigned LIGHT_PCT = 5,
  parameter int unsigned BURST_MS = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick_i,
  input  logic [FB_W-1:0] fb_i,
  input  logic [FB_W-1:0] pwr_i,
  output pfc_mode_e       mode_o,
  output logic            skip_o
);
  localparam logic [FB_W-1:0] NORM_C  = FB_W'(NORM_PCT);
  localparam logic [FB_W-1:0] UV_C    = FB_W'(UV_PCT);
  localparam logic [FB_W-1:0] LIGHT_C = FB_W'(LIGHT_PCT);
  localparam int unsigned     BCW     = $clog2(BURST_MS + 1);
  localparam logic [BCW-1:0]  BLAST_C = BCW'(BURST_MS - 1);

  pfc_mode_e      mode_q, mode_d;
  logic [BCW-1:0] bcnt_q;
  logic           skip_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_STARTUP: if (fb_i >= NORM_C) mode_d = MODE_NORMAL;
      MODE_NORMAL: begin
        if (fb_i < UV_C)            mode_d = MODE_STARTUP;
        else if (pwr_i < LIGHT_C)   mode_d = MODE_BURST;
      end
      MODE_BURST: begin
        if (fb_i < UV_C)            mode_d = MODE_STARTUP;
        else if (pwr_i >= LIGHT_C)  mode_d = MODE_NORMAL;
      end
      default: mode_d = MODE_STARTUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STARTUP;
      bcnt_q <= '0;
      skip_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      if (mode_d != MODE_BURST) begin
        bcnt_q <= '0;
        skip_q <= 1'b0;
      end else if (mode_q != MODE_BURST) begin
        bcnt_q <= '0;
        skip_q <= 1'b1;
      end else if (ms_tick_i) begin
        if (bcnt_q == BLAST_C) begin
          bcnt_q <= '0;
          skip_q <= ~skip_q;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign mode_o = mode_q;
  assign skip_o = skip_q;

  // R1
  startup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_STARTUP && fb_i < NORM_C) |=> (mode_q == MODE_STARTUP));
  // R2
  uv_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_STARTUP && fb_i < UV_C) |=> (mode_q == MODE_STARTUP));
  // R3
  burst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_NORMAL && fb_i >= UV_C && pwr_i < LIGHT_C)
      |=> (mode_q == MODE_BURST && skip_q));
  // R4
  skip_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> (mode_q == MODE_BURST));
endmodule

// File: rtl/pfc_opw_hiccup.sv
module pfc_opw_hiccup #(
  parameter int unsigned FB_W       = 8,
  parameter int unsigned OPW_ON_PCT = 125,
  parameter int unsigned OPW_OFF_PCT = 120,
  parameter int unsigned OPW_MS     = 112,
  parameter int unsigned HICCUP_MS  = 3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick_i,
  input  logic [FB_W-1:0] pwr_i,
  output logic            hiccup_o
);
  localparam logic [FB_W-1:0] ON_C  = FB_W'(OPW_ON_PCT);
  localparam logic [FB_W-1:0] OFF_C = FB_W'(OPW_OFF_PCT);
  localparam int unsigned     FW    = $clog2(OPW_MS + 1);
  localparam int unsigned     HW    = $clog2(HICCUP_MS + 1);
  localparam logic [FW-1:0]   FLAST = FW'(OPW_MS - 1);
  localparam logic [HW-1:0]   HLAST = HW'(HICCUP_MS - 1);

  logic          opw_q, hic_q;
  logic [FW-1:0] fcnt_q;
  logic [HW-1:0] hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opw_q  <= 1'b0;
      hic_q  <= 1'b0;
      fcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      if (pwr_i >= ON_C)     opw_q <= 1'b1;
      else if (pwr_i < OFF_C) opw_q <= 1'b0;

      if (hic_q) begin
        fcnt_q <= '0;
        if (ms_tick_i) begin
          if (hcnt_q == HLAST) begin
            hcnt_q <= '0;
            hic_q  <= 1'b0;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
      end else if (!opw_q) begin
        fcnt_q <= '0;
      end else if (ms_tick_i) begin
        if (fcnt_q == FLAST) begin
          fcnt_q <= '0;
          hic_q  <= 1'b1;
        end else begin
          fcnt_q <= fcnt_q + 1'b1;
        end
      end
    end
  end

  assign hiccup_o = hic_q;

  // R7
  hiccup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hic_q) |-> $past(opw_q && ms_tick_i));
  // R6
  opw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_i >= ON_C) |=> opw_q);
  // R6
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!opw_q && !hic_q) |=> (fcnt_q == '0));
endmodule

// File: rtl/pfc_therm_hold.sv
module pfc_therm_hold #(
  parameter int unsigned TEMP_CLR_MS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick_i,
  input  logic ot_i,
  output logic hold_o
);
  localparam int unsigned   TW    = $clog2(TEMP_CLR_MS + 1);
  localparam logic [TW-1:0] TLAST = TW'(TEMP_CLR_MS - 1);

  logic          hold_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (ot_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && ms_tick_i) begin
      if (cnt_q == TLAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  // R9
  therm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> hold_q);
  // R9
  therm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(ms_tick_i && !ot_i));
endmodule

// File: rtl/pfc_mode_seq.sv
module pfc_mode_seq
  import pfc_seq_pkg::*;
#(
  parameter int unsigned FB_W        = 8,
  parameter int unsigned NORM_PCT    = 99,
  parameter int unsigned UV_PCT      = 90,
  parameter int unsigned LIGHT_PCT   = 5,
  parameter int unsigned OV_ON_PCT   = 108,
  parameter int unsigned OV_OFF_PCT  = 101,
  parameter int unsigned OPW_ON_PCT  = 125,
  parameter int unsigned OPW_OFF_PCT = 120,
  parameter int unsigned BURST_MS    = 10,
  parameter int unsigned OPW_MS      = 112,
  parameter int unsigned HICCUP_MS   = 3000,
  parameter int unsigned TEMP_CLR_MS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick_i,
  input  logic [FB_W-1:0] fb_i,
  input  logic [FB_W-1:0] pwr_i,
  input  logic            ot_i,
  input  logic            stby_n_i,
  output logic [1:0]      mode_o,
  output logic            gate_en_o,
  output logic            burst_skip_o
);
  localparam logic [FB_W-1:0] OV_ON_C  = FB_W'(OV_ON_PCT);
  localparam logic [FB_W-1:0] OV_OFF_C = FB_W'(OV_OFF_PCT);

  pfc_mode_e mode_w;
  logic      skip_w, hiccup_w, therm_w;
  logic      ovp_q, run_q;

  pfc_mode_fsm #(
    .FB_W(FB_W), .NORM_PCT(NORM_PCT), .UV_PCT(UV_PCT),
    .LIGHT_PCT(LIGHT_PCT), .BURST_MS(BURST_MS)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i),
    .fb_i(fb_i), .pwr_i(pwr_i), .mode_o(mode_w), .skip_o(skip_w)
  );

  pfc_opw_hiccup #(
    .FB_W(FB_W), .OPW_ON_PCT(OPW_ON_PCT), .OPW_OFF_PCT(OPW_OFF_PCT),
    .OPW_MS(OPW_MS), .HICCUP_MS(HICCUP_MS)
  ) u_opw (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i),
    .pwr_i(pwr_i), .hiccup_o(hiccup_w)
  );

  pfc_therm_hold #(
    .TEMP_CLR_MS(TEMP_CLR_MS)
  ) u_therm (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick_i),
    .ot_i(ot_i), .hold_o(therm_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= stby_n_i;
      if (fb_i > OV_ON_C)        ovp_q <= 1'b1;
      else if (fb_i <= OV_OFF_C) ovp_q <= 1'b0;
    end
  end

  assign mode_o       = mode_w;
  assign burst_skip_o = skip_w;
  assign gate_en_o    = run_q & ~therm_w & ~ovp_q & ~hiccup_w & ~skip_w;

  // R8
  stby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n_i |=> !gate_en_o);
  // R5
  ovp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_i > OV_ON_C) |=> !gate_en_o);
  // R4
  skip_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_skip_o |-> !gate_en_o);
  // R8
  stby_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_n_i && mode_o == 2'b00 && fb_i < FB_W'(NORM_PCT)) |=> (mode_o == 2'b00));
endmodule

// File: tb/pfc_mode_seq_tb_top.sv
module pfc_mode_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic [7:0] fb = 8'd0;
  logic [7:0] pwr = 8'd50;
  logic       ot = 1'b0;
  logic       stby_n = 1'b1;
  logic [1:0] mode;
  logic       gate_en, skip;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;

  always #5 clk = ~clk;

  pfc_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .fb_i(fb), .pwr_i(pwr),
    .ot_i(ot), .stby_n_i(stby_n), .mode_o(mode), .gate_en_o(gate_en),
    .burst_skip_o(skip)
  );

  // fb, pwr, mode, gate, skip
  localparam logic [19:0] VEC [14] = '{
    {8'd50,  8'd50,  2'd0, 1'b1, 1'b0},  // R1 low feedback stays start-up
    {8'd98,  8'd50,  2'd0, 1'b1, 1'b0},  // R1 one below
    {8'd99,  8'd50,  2'd1, 1'b1, 1'b0},  // R1 nominal reached
    {8'd90,  8'd50,  2'd1, 1'b1, 1'b0},  // R2 band
    {8'd89,  8'd50,  2'd0, 1'b1, 1'b0},  // R2 undervoltage
    {8'd95,  8'd50,  2'd0, 1'b1, 1'b0},  // R2 hysteresis
    {8'd100, 8'd50,  2'd1, 1'b1, 1'b0},  // R1
    {8'd108, 8'd50,  2'd1, 1'b1, 1'b0},  // R5 at limit
    {8'd109, 8'd50,  2'd1, 1'b0, 1'b0},  // R5 overvoltage
    {8'd102, 8'd50,  2'd1, 1'b0, 1'b0},  // R5 hysteresis
    {8'd101, 8'd50,  2'd1, 1'b1, 1'b0},  // R5 recovery
    {8'd100, 8'd4,   2'd2, 1'b0, 1'b1},  // R3 burst entry
    {8'd100, 8'd5,   2'd1, 1'b1, 1'b0},  // R3 burst exit
    {8'd100, 8'd124, 2'd1, 1'b1, 1'b0}   // R6 below threshold
  };

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ms_tick = 1'b1;
      step(1);
      ms_tick = 1'b0;
      step(1);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int m, input int g, input int s);
    chk({req, " mode"}, int'(mode), m);
    chk({req, " gate"}, int'(gate_en), g);
    chk({req, " skip"}, int'(skip), s);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;

  initial begin
    step(2);
    chk_all("R10 in reset", 0, 0, 0);
    rst_n = 1'b1;
    #1;
    chk_all("R10 after release", 0, 0, 0);

    for (int i = 0; i < 14; i++) begin
      fb  = VEC[i][19:12];
      pwr = VEC[i][11:4];
      step(1);
      chk_all($sformatf("vector %0d", i), int'(VEC[i][3:2]), int'(VEC[i][1]), int'(VEC[i][0]));
    end

    // R4 burst alternation
    pwr = 8'd3;
    step(1);
    chk_all("R4 entry", 2, 0, 1);
    ticks(9);
    chk_all("R4 ninth tick", 2, 0, 1);
    ticks(1);
    chk_all("R4 run half", 2, 1, 0);
    ticks(10);
    chk_all("R4 skip again", 2, 0, 1);
    fb = 8'd89;
    step(1);
    chk_all("R3 undervoltage beats burst", 0, 1, 0);
    fb = 8'd100; pwr = 8'd50;
    step(1);
    chk_all("R1 back to normal", 1, 1, 0);

    // R8 standby
    stby_n = 1'b0;
    step(1);
    chk_all("R8 standby", 1, 0, 0);
    fb = 8'd89;
    step(1);
    chk("R8 mode tracks", int'(mode), 0);
    fb = 8'd100;
    step(1);
    stby_n = 1'b1;
    step(1);
    chk_all("R8 release", 1, 1, 0);

    // R9 thermal
    ot = 1'b1;
    step(1);
    chk("R9 flag", int'(gate_en), 0);
    ot = 1'b0;
    ticks(15);
    chk("R9 countdown", int'(gate_en), 0);
    ot = 1'b1;
    step(1);
    ot = 1'b0;
    ticks(15);
    chk("R9 restarted", int'(gate_en), 0);
    ticks(1);
    chk("R9 release", int'(gate_en), 1);

    // R6 persistence timer reset
    pwr = 8'd130;
    step(1);
    ticks(100);
    chk("R6 counting", int'(gate_en), 1);
    pwr = 8'd119;
    step(2);
    pwr = 8'd130;
    step(1);
    ticks(111);
    chk("R6 timer was cleared", int'(gate_en), 1);
    ticks(1);
    chk("R7 hiccup start", int'(gate_en), 0);
    ticks(2999);
    chk("R7 hiccup held", int'(gate_en), 0);
    ticks(1);
    chk("R7 hiccup end", int'(gate_en), 1);
    ticks(50);
    pwr = 8'd122;
    ticks(61);
    chk("R6 hysteresis keeps fault", int'(gate_en), 1);
    ticks(1);
    chk("R7 hiccup repeats", int'(gate_en), 0);
    pwr = 8'd100;
    ticks(3000);
    chk("R7 second end", int'(gate_en), 1);
    ticks(200);
    chk_all("R6 cleared", 1, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule